// File: doc/BRIEF.md
# Set/Clear Interrupt Enable Register Bank

This block holds the enable state for a set of interrupt sources in four memory-mapped registers on a simple 32-bit read/write bus. Two of the registers are mask registers with one enable bit per field. The other two are priority registers with 4-bit fields, where any nonzero level counts as enabled. Three registers are reached through a pair of addresses. Writing to the set address turns bits on without a read-modify-write, and writing to the clear address turns bits off. The fourth register has a single address and takes the written data as it is.

On every accepted write the block compares the old and new value of each field. For each field that changed, it sends a one-cycle enable or disable strobe to the interrupt source wired to that field. A field may instead be wired to a group. A group strobe goes to every member source of the group. A field may also be wired to nothing, and then it only stores its value. The pending logic and vector selection that use these strobes are outside the block.

Register map (byte offsets, compared on address bits 28:0):

| Register | Set / direct | Clear | Width | Field width |
|---|---|---|---|---|
| mask A | 0x040 | 0x060 | 8 | 1 |
| mask B | 0x044 | 0x064 | 8 | 1 |
| level A | 0x080 | 0x0A0 | 16 | 4 |
| level B | 0x0C0 (direct) | none | 16 | 4 |

Field k counts from the top of its register. In mask A, field k drives source k+1. In mask B, field 0 drives group 0 (sources 9 and 10) and field 1 drives group 1 (sources 11 and 12). Fields 2 to 7 of mask B drive nothing. In level A, field k drives source 13+k. In level B, field k drives source 17+k. Strobe bit n belongs to source n, and bit 0 is never used.

Top module: `intc_mask_bank`

## Requirements
- R1: Reset (synchronous, active high) clears every register to 0 and drives both strobe vectors to 0.
- R2: Address bits 31:29 are ignored, so 0xA0000040 reaches the same register as 0x040.
- R3: A write to a set address ORs the low register-width bits of the data into the register. Data bits above the register width have no effect.
- R4: A write to a clear address ANDs the register with the inverted data.
- R5: A write to the direct address of level B stores the low 16 data bits unchanged.
- R6: A read (rd_en high) from either the set address or the clear address returns the current register value on rdata in the same cycle, zero-extended.
- R7: Field k occupies the top-most field first. In a mask register, bit 7 is field 0. In a level register, bits 15:12 are field 0.
- R8: A field whose value changes to nonzero raises the enable strobe of its target. A field whose value changes to zero raises the disable strobe. This includes a level field that moves from one nonzero value to another. An unchanged field raises nothing.
- R9: A strobe from a field wired to a group goes to every member source of that group.
- R10: A field wired to nothing stores its value but raises no strobe, and strobe bit 0 never rises.
- R11: An access to any other address raises bus_err in the same cycle. A read from such an address returns 0, and a write to it changes no register and raises no strobe.
- R12: The strobes for a write are high for exactly the one cycle in which the new register value is first visible. They are 0 in every cycle that follows a cycle with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request this cycle |
| rd_en | input | 1 | Read request this cycle |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| bus_err | output | 1 | Access hit no register |
| en_stb | output | 21 | Per-source enable strobe |
| dis_stb | output | 21 | Per-source disable strobe |

## Verification
The bench goes after the cases that a field-by-field comparison most easily gets wrong:
- Rewriting an unchanged value must raise no strobe. A design that compares whole registers, or that strobes every field it writes, would pulse every source.
- A level field moving from 3 to 7 must raise a second enable strobe. A design that only detects zero/nonzero transitions would miss it.
- A write to a clear address must leave its untouched fields silent.
- Group fields must reach both members, and the spare fields of mask B must stay silent.
- Aliased upper addresses, unmapped accesses and data beyond the register width catch a decoder that compares all 32 address bits or lets stray data bits through.
- The bench also checks that strobes drop after one cycle and that a reset in mid-run clears the registers.

// File: rtl/intc_mask_pkg.sv
package intc_mask_pkg;

    localparam int BUS_W      = 32;
    localparam int NUM_REGS   = 4;
    localparam int MAX_FIELDS = 8;
    localparam int NUM_SRC    = 21;
    localparam int NUM_GRP    = 2;
    localparam int IDX_W      = $clog2(NUM_SRC);
    localparam logic [BUS_W-1:0] DEC_MASK = 32'h1FFF_FFFF;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_SRC,
        TGT_GRP
    } tgt_kind_e;

    typedef struct packed {
        tgt_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } tgt_t;

    // per-field change events of one register
    typedef struct packed {
        logic [MAX_FIELDS-1:0] on;
        logic [MAX_FIELDS-1:0] off;
    } fld_evt_t;

    function automatic int reg_width(input int r);
        return (r < 2) ? 8 : 16;
    endfunction

    function automatic int field_width(input int r);
        return (r < 2) ? 1 : 4;
    endfunction

    function automatic int num_fields(input int r);
        return reg_width(r) / field_width(r);
    endfunction

    function automatic bit has_clear(input int r);
        return r != 3;
    endfunction

    function automatic logic [BUS_W-1:0] set_addr(input int r);
        case (r)
            0:       return 32'h040;
            1:       return 32'h044;
            2:       return 32'h080;
            default: return 32'h0C0;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] clr_addr(input int r);
        case (r)
            0:       return 32'h060;
            1:       return 32'h064;
            default: return 32'h0A0;
        endcase
    endfunction

    function automatic tgt_t field_target(input int r, input int k);
        tgt_t t;
        t.kind = TGT_NONE;
        t.idx  = '0;
        case (r)
            0: begin t.kind = TGT_SRC; t.idx = IDX_W'(k + 1); end
            1: if (k < NUM_GRP) begin t.kind = TGT_GRP; t.idx = IDX_W'(k); end
            2: begin t.kind = TGT_SRC; t.idx = IDX_W'(k + 13); end
            default: begin t.kind = TGT_SRC; t.idx = IDX_W'(k + 17); end
        endcase
        return t;
    endfunction

    function automatic logic [NUM_SRC-1:0] group_members(input int g);
        logic [NUM_SRC-1:0] m;
        m = '0;
        m[9 + 2*g]  = 1'b1;
        m[10 + 2*g] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/intc_field_reg.sv
module intc_field_reg
    import intc_mask_pkg::*;
#(
    parameter int               W       = 8,
    parameter int               FW      = 1,
    parameter bit               HAS_CLR = 1'b1,
    parameter logic [BUS_W-1:0] SET_A   = 32'h040,
    parameter logic [BUS_W-1:0] CLR_A   = 32'h060
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] dec_addr,
    input  logic [BUS_W-1:0] wdata,
    output logic             hit,
    output logic [W-1:0]     value,
    output fld_evt_t         evt
);
    localparam int NF = W / FW;

    logic         hit_set, hit_clr, do_wr;
    logic [W-1:0] wd, nxt;
    logic [MAX_FIELDS-1:0] on_v, off_v;

    assign wd      = W'(wdata);
    assign hit_set = (dec_addr == SET_A);
    assign hit_clr = HAS_CLR && (dec_addr == CLR_A);
    assign hit     = hit_set || hit_clr;
    assign do_wr   = wr_en && hit;

    always_comb begin
        if (!HAS_CLR)     nxt = wd;
        else if (hit_set) nxt = value | wd;
        else              nxt = value & ~wd;
    end

    always_ff @(posedge clk) begin
        if (rst)        value <= '0;
        else if (do_wr) value <= nxt;
    end

    for (genvar k = 0; k < MAX_FIELDS; k++) begin : g_fld
        if (k < NF) begin : g_used
            localparam int LSB = W - (k + 1) * FW;
            logic chg;
            assign chg      = do_wr && (value[LSB +: FW] != nxt[LSB +: FW]);
            assign on_v[k]  = chg && (|nxt[LSB +: FW]);
            assign off_v[k] = chg && !(|nxt[LSB +: FW]);
        end else begin : g_spare
            assign on_v[k]  = 1'b0;
            assign off_v[k] = 1'b0;
        end
    end

    assign evt.on  = on_v;
    assign evt.off = off_v;

    if (HAS_CLR) begin : g_dual_chk
        // R3
        set_keeps_bits_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && hit_set) |=> (($past(value) & ~value) == '0));
        // R4
        clr_adds_no_bits_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && hit_clr) |=> ((value & ~$past(value)) == '0));
    end

endmodule

// File: rtl/intc_strobe_map.sv
module intc_strobe_map
    import intc_mask_pkg::*;
(
    input  fld_evt_t           evts [NUM_REGS],
    output logic [NUM_SRC-1:0] en_nxt,
    output logic [NUM_SRC-1:0] dis_nxt
);
    always_comb begin
        en_nxt  = '0;
        dis_nxt = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            for (int k = 0; k < MAX_FIELDS; k++) begin
                tgt_t t;
                logic [NUM_SRC-1:0] dst;
                t   = field_target(r, k);
                dst = '0;
                if (k < num_fields(r)) begin
                    if (t.kind == TGT_SRC)      dst[t.idx] = 1'b1;
                    else if (t.kind == TGT_GRP) dst = group_members(int'(t.idx));
                end
                if (evts[r].on[k])  en_nxt  = en_nxt  | dst;
                if (evts[r].off[k]) dis_nxt = dis_nxt | dst;
            end
        end
    end
endmodule

// File: rtl/intc_mask_bank.sv
module intc_mask_bank
    import intc_mask_pkg::*;
#(
    parameter int DATA_W = BUS_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [BUS_W-1:0]   addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               bus_err,
    output logic [NUM_SRC-1:0] en_stb,
    output logic [NUM_SRC-1:0] dis_stb
);
    logic [BUS_W-1:0]                 dec_addr;
    logic [NUM_REGS-1:0]              hits;
    logic [NUM_REGS-1:0][DATA_W-1:0]  reg_val;
    fld_evt_t                         evts [NUM_REGS];
    logic [NUM_SRC-1:0]               en_nxt, dis_nxt;

    assign dec_addr = addr & DEC_MASK;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        localparam int RW = reg_width(r);
        logic [RW-1:0] v;
        intc_field_reg #(
            .W       (RW),
            .FW      (field_width(r)),
            .HAS_CLR (has_clear(r)),
            .SET_A   (set_addr(r)),
            .CLR_A   (clr_addr(r))
        ) u_reg (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_en),
            .dec_addr (dec_addr),
            .wdata    (wdata),
            .hit      (hits[r]),
            .value    (v),
            .evt      (evts[r])
        );
        assign reg_val[r] = DATA_W'(v);
    end

    intc_strobe_map u_map (
        .evts    (evts),
        .en_nxt  (en_nxt),
        .dis_nxt (dis_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_stb  <= '0;
            dis_stb <= '0;
        end else begin
            en_stb  <= en_nxt;
            dis_stb <= dis_nxt;
        end
    end

    always_comb begin
        rdata = '0;
        for (int r = 0; r < NUM_REGS; r++)
            if (rd_en && hits[r]) rdata = rdata | reg_val[r];
    end

    assign bus_err = (wr_en || rd_en) && (hits == '0);

    // R11
    miss_write_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && bus_err) |=> ($stable(reg_val) && en_stb == '0 && dis_stb == '0));
    // R12
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (en_stb == '0 && dis_stb == '0));
    // R8
    no_dual_direction_chk: assert property (@(posedge clk) disable iff (rst)
        (en_stb & dis_stb) == '0);
    // R10
    src_zero_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en_stb[0] && !dis_stb[0]);
    // R11
    single_hit_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hits));

endmodule

// File: tb/intc_mask_bank_test.sv
module intc_mask_bank_test;
    import intc_mask_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0]        addr = '0, wdata = '0;
    logic [31:0]        rdata;
    logic               bus_err;
    logic [20:0]        en_stb, dis_stb;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    intc_mask_bank uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .bus_err(bus_err),
        .en_stb(en_stb), .dis_stb(dis_stb)
    );

    typedef struct packed {
        logic        is_rd;
        logic [31:0] a;
        logic [31:0] d;
        logic [31:0] exp_rd;
        logic [20:0] exp_en;
        logic [20:0] exp_dis;
        logic        exp_err;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{0, 32'h040,       32'h81,        32'h0,    21'h000102, 21'h0,      0, 4'd7},  // R7 R3
        '{1, 32'h060,       32'h0,         32'h81,   21'h0,      21'h0,      0, 4'd6},  // R6
        '{1, 32'h040,       32'h0,         32'h81,   21'h0,      21'h0,      0, 4'd6},  // R6
        '{0, 32'h040,       32'h81,        32'h0,    21'h0,      21'h0,      0, 4'd8},  // R8 unchanged
        '{0, 32'h040,       32'h40,        32'h0,    21'h000004, 21'h0,      0, 4'd3},  // R3
        '{0, 32'h060,       32'h80,        32'h0,    21'h0,      21'h000002, 0, 4'd4},  // R4
        '{0, 32'hA000_0040, 32'h02,        32'h0,    21'h000080, 21'h0,      0, 4'd2},  // R2
        '{1, 32'hE000_0060, 32'h0,         32'h43,   21'h0,      21'h0,      0, 4'd2},  // R2
        '{0, 32'h044,       32'h80,        32'h0,    21'h000600, 21'h0,      0, 4'd9},  // R9
        '{0, 32'h044,       32'h3F,        32'h0,    21'h0,      21'h0,      0, 4'd10}, // R10
        '{1, 32'h064,       32'h0,         32'hBF,   21'h0,      21'h0,      0, 4'd10}, // R10
        '{0, 32'h064,       32'hC0,        32'h0,    21'h0,      21'h000600, 0, 4'd9},  // R9
        '{0, 32'h080,       32'h3000,      32'h0,    21'h002000, 21'h0,      0, 4'd7},  // R7
        '{0, 32'h080,       32'h0400,      32'h0,    21'h004000, 21'h0,      0, 4'd7},  // R7
        '{0, 32'h080,       32'h4000,      32'h0,    21'h002000, 21'h0,      0, 4'd8},  // R8 3->7
        '{0, 32'h0A0,       32'h7000,      32'h0,    21'h0,      21'h002000, 0, 4'd4},  // R4
        '{0, 32'h0C0,       32'h00A5,      32'h0,    21'h180000, 21'h0,      0, 4'd5},  // R5
        '{0, 32'h0C0,       32'h5005,      32'h0,    21'h020000, 21'h080000, 0, 4'd5},  // R5
        '{1, 32'h0C0,       32'h0,         32'h5005, 21'h0,      21'h0,      0, 4'd5},  // R5
        '{1, 32'h100,       32'h0,         32'h0,    21'h0,      21'h0,      1, 4'd11}, // R11
        '{0, 32'h0E0,       32'hFFFF,      32'h0,    21'h0,      21'h0,      1, 4'd11}, // R11
        '{1, 32'h040,       32'h0,         32'h43,   21'h0,      21'h0,      0, 4'd11}, // R11
        '{1, 32'h0A0,       32'h0,         32'h0400, 21'h0,      21'h0,      0, 4'd11}, // R11
        '{0, 32'h040,       32'hFFFF_FF00, 32'h0,    21'h0,      21'h0,      0, 4'd3},  // R3 wide data
        '{1, 32'h040,       32'h0,         32'h43,   21'h0,      21'h0,      0, 4'd3}   // R3
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // drive at a falling edge; read data and error are combinational,
    // strobes appear after the next rising edge
    task automatic bus_op(input logic rd, input logic [31:0] a, input logic [31:0] d,
                          input string tag, input logic [31:0] exp_rd, input logic exp_err,
                          input logic [20:0] exp_en, input logic [20:0] exp_dis);
        wr_en = !rd; rd_en = rd; addr = a; wdata = d;
        #1;
        if (rd) chk({tag, " rdata"}, rdata, exp_rd);
        chk({tag, " bus_err"}, 32'(bus_err), 32'(exp_err));
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk({tag, " en_stb"},  32'(en_stb),  32'(exp_en));
        chk({tag, " dis_stb"}, 32'(dis_stb), 32'(exp_dis));
    endtask

    task automatic read_all_zero(input string tag);
        for (int i = 0; i < 4; i++) begin
            logic [31:0] a;
            a = (i == 0) ? 32'h040 : (i == 1) ? 32'h064 : (i == 2) ? 32'h080 : 32'h0C0;
            bus_op(1'b1, a, 32'h0, tag, 32'h0, 1'b0, 21'h0, 21'h0);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 state out of reset
        chk("R1 en_stb after reset",  32'(en_stb),  32'h0);
        chk("R1 dis_stb after reset", 32'(dis_stb), 32'h0);
        read_all_zero("R1 reset value");

        for (int i = 0; i < NV; i++) begin
            bus_op(VECS[i].is_rd, VECS[i].a, VECS[i].d,
                   $sformatf("R%0d vec%0d", VECS[i].req, i),
                   VECS[i].exp_rd, VECS[i].exp_err, VECS[i].exp_en, VECS[i].exp_dis);
        end

        // R12 strobe lasts one cycle: mask A bit 0 is field 7, source 8
        bus_op(1'b0, 32'h060, 32'h01, "R12 clear src8", 32'h0, 1'b0, 21'h0, 21'h000100);
        @(posedge clk);
        @(negedge clk);
        chk("R12 en_stb one cycle later",  32'(en_stb),  32'h0);
        chk("R12 dis_stb one cycle later", 32'(dis_stb), 32'h0);
        bus_op(1'b1, 32'h040, 32'h0, "R12 value kept", 32'h42, 1'b0, 21'h0, 21'h0);

        // R1 reset in mid-run
        bus_op(1'b0, 32'h044, 32'h40, "R9 group1", 32'h0, 1'b0, 21'h001800, 21'h0);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 en_stb after mid reset", 32'(en_stb), 32'h0);
        read_all_zero("R1 mid-run reset");

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule